// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block sits in front of a 16-bit DAC. It takes a framed serial write made of an active-low chip select, a serial clock and a serial data line, and produces the parallel value for the DAC holding register. A one-cycle strobe marks each write. The three serial lines are asynchronous to the block. Each line passes through a synchronizer into a faster system clock, and every serial edge is detected by comparing successive samples in that clock domain.

A frame opens when chip select falls and closes when it rises. While the frame is open, each rising serial clock edge shifts one data bit in, most significant bit first. The block counts these edges. The holding register is written only when chip select rises, and only if at least 16 bits arrived. When more than 16 bits arrived, the earlier bits fall out and the last 16 are kept.

Chip select must stay high for a configurable minimum number of system cycles between frames. If the high time is shorter, the next falling edge does not start a valid frame, and that frame is thrown away.

Top module: `serial_dac_rx`

## Requirements
- R1: After reset, the DAC output `dac_o` is all zeros and `upd_o` is low.
- R2: While chip select is low, each rising serial clock edge captures one data bit, most significant bit first. A frame of exactly 16 bits puts the first bit sent on `dac_o[15]` and the last bit sent on `dac_o[0]`.
- R3: `dac_o` changes only as a result of a chip-select rising edge. Reaching the 16th serial clock edge while chip select is still low leaves `dac_o` unchanged.
- R4: A frame with fewer than 16 rising serial clock edges is discarded. `dac_o` keeps its previous value and no strobe is produced.
- R5: A frame with more than 16 rising serial clock edges writes the last 16 bits received before chip select rose. The earlier bits are ignored.
- R6: `upd_o` is high for exactly one system cycle for each write of `dac_o`, and it stays low for every discarded frame.
- R7: If chip select was high for fewer than `MIN_HIGH` system cycles before it falls, the frame that follows is discarded.
- R8: Serial clock edges while chip select is high produce no strobe, do not change `dac_o`, and do not change the bit count.
- R9: The bit counter saturates instead of wrapping. A 40-bit frame is accepted and writes its last 16 bits.
- R10: The falling edge of chip select clears the bit count. Two back-to-back 10-bit frames are both discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Asynchronous active-low chip select, frames a transfer |
| sclk_i | input | 1 | Asynchronous serial clock; data is captured on its rising edge |
| sdi_i | input | 1 | Asynchronous serial data, most significant bit first |
| dac_o | output | DATA_W | DAC holding register value |
| upd_o | output | 1 | One-cycle strobe, high in the cycle after `dac_o` is written |

## Verification
The bound checker covers, on every cycle, the properties that can be stated over time:
- the reset value;
- that each strobe follows a detected chip-select rise;
- that each strobe follows a bit count of at least 16;
- that the strobe is a single-cycle pulse;
- that `dac_o` holds its value whenever no strobe occurs;
- that the bit count stays frozen while chip select is high.

Some behaviour depends on how a whole frame was built, and only the bench scenarios can show it: which 16 bits are kept from a long frame, the rejection that follows a too-short high time, saturation on a 40-bit frame, and the count being cleared between short frames. The bench runs each of these against a behavioural reference model that is compared on every clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Default configuration values
    localparam int unsigned DEF_DATA_W      = 16;
    localparam int unsigned DEF_MIN_HIGH    = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Synchronized serial pin sample
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
    } pins_t;

    // Edge and level events derived from two consecutive samples
    typedef struct packed {
        logic cs_fall;    // chip select went low
        logic cs_rise;    // chip select went high
        logic cs_high;    // chip select currently high
        logic held_low;   // chip select low in both samples
        logic sclk_rise;  // serial clock went high
        logic sdi;        // data bit aligned with the current sample
    } edges_t;

    // Frame tracking state
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,   // chip select high, no frame open
        FR_LIVE = 2'd1,   // valid frame open
        FR_VOID = 2'd2    // frame opened after a short high time, discarded
    } frame_st_e;

    // Pin values at reset: chip select deasserted, clock and data low
    function automatic pins_t pins_idle();
        pins_t p;
        p.cs_n = 1'b1;
        p.sclk = 1'b0;
        p.sdi  = 1'b0;
        return p;
    endfunction

    // Events from the previous and current samples
    function automatic edges_t derive_edges(pins_t prev, pins_t cur);
        edges_t e;
        e.cs_fall   = prev.cs_n & ~cur.cs_n;
        e.cs_rise   = ~prev.cs_n & cur.cs_n;
        e.cs_high   = cur.cs_n;
        e.held_low  = ~prev.cs_n & ~cur.cs_n;
        e.sclk_rise = ~prev.sclk & cur.sclk;
        e.sdi       = cur.sdi;
        return e;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  pins_t  cur_i,
    output edges_t ev_o
);

    pins_t prev_q;

    // Keep the previous sample so that edges can be detected
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= pins_idle();
        end else begin
            prev_q <= cur_i;
        end
    end

    assign ev_o = derive_edges(prev_q, cur_i);

endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned MIN_HIGH = DEF_MIN_HIGH,
    parameter int unsigned CNT_W    = $clog2(DATA_W) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  edges_t            ev_i,
    output logic              commit_o,
    output logic [DATA_W-1:0] word_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);

    localparam int unsigned HI_W = $clog2(MIN_HIGH + 1);
    localparam logic [HI_W-1:0]  HI_LIM  = HI_W'(MIN_HIGH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_REQ = CNT_W'(DATA_W);

    frame_st_e         st_q, st_d;
    logic [HI_W-1:0]   high_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              shift_en;
    logic              gap_ok;

    // Count how long chip select has been high; the count saturates at the limit
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            high_q <= '0;
        end else if (!ev_i.cs_high) begin
            high_q <= '0;
        end else if (high_q != HI_LIM) begin
            high_q <= high_q + 1'b1;
        end
    end

    assign gap_ok = (high_q >= HI_LIM);

    // Frame state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE: if (ev_i.cs_fall) st_d = gap_ok ? FR_LIVE : FR_VOID;
            FR_LIVE: if (ev_i.cs_rise) st_d = FR_IDLE;
            FR_VOID: if (ev_i.cs_rise) st_d = FR_IDLE;
            default: st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Shift only inside a valid frame, on a serial clock rise, with chip select held low
    assign shift_en = (st_q == FR_LIVE) && ev_i.held_low && ev_i.sclk_rise;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (ev_i.cs_fall) begin
            cnt_q <= '0;
        end else if (shift_en && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
        end else if (shift_en) begin
            shreg_q <= {shreg_q[DATA_W-2:0], ev_i.sdi};
        end
    end

    assign commit_o  = ev_i.cs_rise && (st_q == FR_LIVE) && (cnt_q >= CNT_REQ);
    assign word_o    = shreg_q;
    assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
    import sdac_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned MIN_HIGH    = DEF_MIN_HIGH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic [DATA_W-1:0] dac_o,
    output logic              upd_o
);

    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

    logic [2:0]        pins_raw, pins_sync;
    pins_t             pins_s;
    edges_t            ev;
    logic              commit;
    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    logic              cs_rise_w, cs_high_w;

    assign pins_raw = {cs_n_i, sclk_i, sdi_i};

    sdac_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'(pins_idle()))
    ) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pins_raw),
        .q_o   (pins_sync)
    );

    assign pins_s = pins_t'(pins_sync);

    sdac_edge edge_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cur_i (pins_s),
        .ev_o  (ev)
    );

    sdac_frame #(
        .DATA_W   (DATA_W),
        .MIN_HIGH (MIN_HIGH),
        .CNT_W    (CNT_W)
    ) frame_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ev_i      (ev),
        .commit_o  (commit),
        .word_o    (word),
        .bit_cnt_o (bit_cnt)
    );

    // DAC holding register and update strobe
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dac_o <= '0;
            upd_o <= 1'b0;
        end else begin
            upd_o <= commit;
            if (commit) begin
                dac_o <= word;
            end
        end
    end

    // Event taps for the bound checker
    assign cs_rise_w = ev.cs_rise;
    assign cs_high_w = ev.cs_high;

endmodule

// File: rtl/serial_dac_rx_chk.sv
module serial_dac_rx_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] dac,
    input logic              upd,
    input logic              cs_rise,
    input logic              cs_high,
    input logic [CNT_W-1:0]  bit_cnt
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (dac == '0) && !upd);

    // R3
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        upd |-> $past(cs_rise));

    // R3
    dac_hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !upd |-> $stable(dac));

    // R4
    enough_bits_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        upd |-> ($past(bit_cnt) >= CNT_W'(DATA_W)));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        upd |=> !upd);

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        cs_high |=> $stable(bit_cnt));

endmodule

bind serial_dac_rx serial_dac_rx_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk     (clk_i),
    .rst     (rst_i),
    .dac     (dac_o),
    .upd     (upd_o),
    .cs_rise (cs_rise_w),
    .cs_high (cs_high_w),
    .bit_cnt (bit_cnt)
);

// File: tb/serial_dac_rx_tb_top.sv
`timescale 1ns/1ps
module serial_dac_rx_tb_top;

    localparam int MIN_HIGH = 4;
    localparam int HALF     = 3;   // system cycles per serial clock phase

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] dac;
    logic        upd;

    int n_chk  = 0;
    int n_fail = 0;
    int strobes = 0;

    always #10 clk = ~clk;   // 50 MHz

    serial_dac_rx #(.DATA_W(16), .MIN_HIGH(MIN_HIGH), .SYNC_STAGES(2)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .cs_n_i (cs_n),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .dac_o  (dac),
        .upd_o  (upd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: pins are seen after two cycles of synchronization
    logic [2:0]  hist[$];
    logic [15:0] m_dac;
    logic        m_upd;
    int          m_run, m_bits;
    bit          m_live;
    logic [15:0] m_word;

    always @(posedge clk) begin
        logic [2:0] cur, prv;
        if (rst) begin
            hist = '{3'b100, 3'b100, 3'b100, 3'b100};
            m_dac = '0; m_upd = 1'b0; m_run = 0; m_bits = 0; m_live = 0; m_word = '0;
        end else begin
            hist.push_front({cs_n, sclk, sdi});
            void'(hist.pop_back());
            cur = hist[2];
            prv = hist[3];
            m_upd = 1'b0;
            if (prv[2] && !cur[2]) begin
                m_live = (m_run >= MIN_HIGH);
                m_bits = 0;
            end else if (!prv[2] && cur[2]) begin
                if (m_live && m_bits >= 16) begin
                    m_dac = m_word;
                    m_upd = 1'b1;
                end
                m_live = 0;
            end else if (!prv[2] && !cur[2] && !prv[1] && cur[1] && m_live) begin
                m_word = {m_word[14:0], cur[0]};
                m_bits++;
            end
            m_run = cur[2] ? ((m_run < MIN_HIGH) ? m_run + 1 : m_run) : 0;
        end
    end

    // Compare with the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R2/R3 model dac", 64'(dac), 64'(m_dac));
            check("R6 model strobe", 64'(upd), 64'(m_upd));
            if (upd) strobes++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_frame();
        @(negedge clk);
        cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic shift_bits(input int n, input logic [63:0] val);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = val[i];
            sclk = 1'b0;
            wait_cyc(HALF);
            sclk = 1'b1;
            wait_cyc(HALF);
        end
        sclk = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic end_frame(input int gap);
        cs_n = 1'b1;
        wait_cyc(gap);
    endtask

    task automatic frame(input int n, input logic [63:0] val, input int gap);
        begin_frame();
        shift_bits(n, val);
        end_frame(gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 reset dac", 64'(dac), 64'h0);
        check("R1 reset strobe", 64'(upd), 64'h0);
        wait_cyc(8);

        // R2: exact 16-bit frame, MSB first
        base = strobes;
        frame(16, 64'hA5C3, 10);
        check("R2 word A5C3", 64'(dac), 64'hA5C3);
        check("R6 one strobe", 64'(strobes - base), 64'd1);

        frame(16, 64'hFFFF, 10);
        check("R2 word FFFF", 64'(dac), 64'hFFFF);
        frame(16, 64'h0000, 10);
        check("R2 word 0000", 64'(dac), 64'h0);

        // R3: no update before chip select rises
        base = strobes;
        begin_frame();
        shift_bits(16, 64'h1234);
        wait_cyc(8);
        check("R3 held before rise", 64'(dac), 64'h0);
        check("R3 no strobe before rise", 64'(strobes - base), 64'd0);
        end_frame(10);
        check("R3 update at rise", 64'(dac), 64'h1234);

        // R4: short frames are discarded
        base = strobes;
        frame(15, 64'h7FFF, 10);
        check("R4 15-bit frame", 64'(dac), 64'h1234);
        frame(0, 64'h0, 10);
        check("R4 empty frame", 64'(dac), 64'h1234);
        check("R6 no strobe on discard", 64'(strobes - base), 64'd0);

        // R5: long frame keeps the last 16 bits
        frame(20, 64'hABCDE, 10);
        check("R5 20-bit frame", 64'(dac), 64'hBCDE);

        // R9: 40-bit frame, counter must not wrap
        frame(40, 64'h12_3456_789A, 10);
        check("R9 40-bit frame", 64'(dac), 64'h789A);

        // R10: counter cleared on each chip select fall
        base = strobes;
        frame(10, 64'h3FF, 10);
        frame(10, 64'h2AA, 10);
        check("R10 two short frames", 64'(dac), 64'h789A);
        check("R10 no strobe", 64'(strobes - base), 64'd0);

        // R8: serial clock toggling while chip select is high
        base = strobes;
        for (int i = 0; i < 20; i++) begin
            sdi  = i[1];
            sclk = ~sclk;
            wait_cyc(2);
        end
        sclk = 1'b0;
        wait_cyc(8);
        check("R8 dac unchanged", 64'(dac), 64'h789A);
        check("R8 no strobe", 64'(strobes - base), 64'd0);

        // R7: a chip-select high time that is too short voids the next frame
        base = strobes;
        frame(16, 64'h0F0F, 1);
        frame(16, 64'hF0F0, 10);
        check("R7 short gap frame voided", 64'(dac), 64'h0F0F);
        check("R7 strobe count", 64'(strobes - base), 64'd1);
        frame(16, 64'h5555, 10);
        check("R7 recovery", 64'(dac), 64'h5555);

        wait_cyc(5);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule